// File: doc/BRIEF.md
# Duplex Time-Slot Input Multiplexer

This block lets a transmit channel and a receive channel share one cipher datapath that accepts a block on every clock. It produces a free-running slot signal that names the channel owning the current cycle. In each cycle it registers the owning channel's 128-bit text, 96-bit IV, packet-start flag and pass-through flag onto one datapath input bus, and tags that bus with a channel bit. Each channel therefore moves one block every second clock, at half the datapath rate.

The IV and pass-through setting are captured on an accepted packet start and held for that channel until its next accepted start. Input changes in the middle of a packet have no effect on what reaches the datapath. A start pulse raised in the wrong slot is dropped, and a sticky error flag records it.

On the return side the engine hands back a channel bit with its single-bit text-valid, text-first and tag-valid flags. The block registers these into separate transmit and receive flags. The 128-bit text and tag buses are registered but not split, so one output text bus and one output tag bus serve both channels.

Top module: `duplex_slot_mux`

## Requirements
- R1: The slot output `txSlot` is 1 while reset is asserted and in the first cycle after it is released. After that it inverts on every rising clock edge, whether or not any packet is in flight. A value of 1 means the transmit channel owns the cycle.
- R2: One cycle after a cycle with `txSlot`=1, `dpChan` is 1 and `dpText` equals the transmit text sampled in that cycle. One cycle after a cycle with `txSlot`=0, `dpChan` is 0 and `dpText` equals the receive text.
- R3: `dpFirst` is 1 exactly one cycle after a cycle in which either `txFirst` was 1 with `txSlot`=1, or `rxFirst` was 1 with `txSlot`=0. In all other cycles it is 0.
- R4: A start in the wrong slot (`txFirst` with `txSlot`=0, or `rxFirst` with `txSlot`=1) does not produce `dpFirst`. It does not change the held IV or pass-through value of either channel. It sets `protoErr` on the next cycle, and `protoErr` stays 1 until reset.
- R5: On an accepted start, `dpIv` and `dpPass` carry the IV and pass-through inputs of that cycle. On every later cycle of that channel, they carry the values captured at that channel's most recent accepted start, whatever the inputs are then, or 0 if no start has been accepted since reset.
- R6: One cycle after the return flags are sampled, `txOutValid`, `txOutFirst` and `txTagValid` copy `retTextValid`, `retTextFirst` and `retTagValid` when `retChan` was 1, and are 0 otherwise. The receive flags behave the same way when `retChan` was 0. A return tagged for receive never raises a transmit flag.
- R7: `outText` and `outTag` equal `retText` and `retTag` one cycle later, shared by both channels.
- R8: While reset is asserted, all datapath-side outputs, all per-channel flags, both shared buses and `protoErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| txFirst | input | 1 | Transmit packet start, valid in slot 1 |
| txPass | input | 1 | Transmit pass-through request, sampled on start |
| txIv | input | 96 | Transmit IV, sampled on start |
| txText | input | 128 | Transmit text block |
| rxFirst | input | 1 | Receive packet start, valid in slot 0 |
| rxPass | input | 1 | Receive pass-through request, sampled on start |
| rxIv | input | 96 | Receive IV, sampled on start |
| rxText | input | 128 | Receive text block |
| txSlot | output | 1 | Slot owner, 1 = transmit, 0 = receive |
| dpText | output | 128 | Text block to the shared datapath |
| dpIv | output | 96 | IV of the owning channel |
| dpFirst | output | 1 | First block of a packet |
| dpPass | output | 1 | Pass-through setting of the owning channel |
| dpChan | output | 1 | Channel tag of the block, 1 = transmit |
| retTextValid | input | 1 | Engine output text valid |
| retTextFirst | input | 1 | Engine output text is first of packet |
| retTagValid | input | 1 | Engine output tag valid |
| retChan | input | 1 | Channel tag returned with the engine output |
| retText | input | 128 | Engine output text |
| retTag | input | 128 | Engine output tag |
| txOutValid | output | 1 | Output text valid for transmit |
| txOutFirst | output | 1 | First output text block for transmit |
| txTagValid | output | 1 | Output tag valid for transmit |
| rxOutValid | output | 1 | Output text valid for receive |
| rxOutFirst | output | 1 | First output text block for receive |
| rxTagValid | output | 1 | Output tag valid for receive |
| outText | output | 128 | Shared output text bus |
| outTag | output | 128 | Shared output tag bus |
| protoErr | output | 1 | Sticky misaligned-start error |

## Verification
Several properties are checked on every cycle. The slot alternates after reset. The error flag stays set once raised. A misaligned start always raises the error flag. The two channels' start strobes are never active together. A transmit flag never follows a return tagged for receive, and a transmit and a receive flag are never high together. Other behaviour needs a cycle-by-cycle model in the bench's sweep. That model covers the exact routing of text into the datapath register and the holding of the IV and pass-through values across a packet while the inputs keep changing. It also covers the one-cycle copy of the shared buses and the dropping of misaligned starts without disturbing the held values.

// File: rtl/slot_mux_pkg.sv
package slot_mux_pkg;

  localparam int unsigned NUM_CHAN = 2;
  localparam bit CHAN_TX = 1'b1;
  localparam bit CHAN_RX = 1'b0;

  typedef struct packed {
    logic slot;       // 1: transmit owns this cycle
    logic txStartOk;  // transmit start accepted this cycle
    logic rxStartOk;  // receive start accepted this cycle
  } slotStrb_t;

endpackage

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_mux_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      txFirst,
  input  logic      rxFirst,
  output slotStrb_t strb,
  output logic      protoErr
);

  logic slotQ;
  logic errQ;
  logic badStart;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) slotQ <= 1'b1;
    else     slotQ <= ~slotQ;
  end

  assign badStart = (txFirst && !slotQ) || (rxFirst && slotQ);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           errQ <= 1'b0;
    else if (badStart) errQ <= 1'b1;
  end

  always_comb begin
    strb.slot      = slotQ;
    strb.txStartOk = txFirst && slotQ;
    strb.rxStartOk = rxFirst && !slotQ;
  end

  assign protoErr = errQ;

  // R1
  slot_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (slotQ != $past(slotQ)));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(errQ)) |-> errQ);

  // R4
  misaligned_err_chk: assert property (@(posedge clk) disable iff (rst)
    ((txFirst && !slotQ) || (rxFirst && slotQ)) |=> errQ);

  // R3
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.txStartOk, strb.rxStartOk}));

endmodule

// File: rtl/slot_datapath.sv
module slot_datapath
  import slot_mux_pkg::*;
#(
  parameter int unsigned TEXT_W = 128,
  parameter int unsigned IV_W   = 96,
  parameter int unsigned TAG_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  slotStrb_t         strb,
  input  logic              txPass,
  input  logic [IV_W-1:0]   txIv,
  input  logic [TEXT_W-1:0] txText,
  input  logic              rxPass,
  input  logic [IV_W-1:0]   rxIv,
  input  logic [TEXT_W-1:0] rxText,
  output logic [TEXT_W-1:0] dpText,
  output logic [IV_W-1:0]   dpIv,
  output logic              dpFirst,
  output logic              dpPass,
  output logic              dpChan,
  input  logic              retTextValid,
  input  logic              retTextFirst,
  input  logic              retTagValid,
  input  logic              retChan,
  input  logic [TEXT_W-1:0] retText,
  input  logic [TAG_W-1:0]  retTag,
  output logic              txOutValid,
  output logic              txOutFirst,
  output logic              txTagValid,
  output logic              rxOutValid,
  output logic              rxOutFirst,
  output logic              rxTagValid,
  output logic [TEXT_W-1:0] outText,
  output logic [TAG_W-1:0]  outTag
);

  localparam int unsigned CH_W = $clog2(NUM_CHAN);

  // per-channel views, index 1 = transmit, 0 = receive
  logic [TEXT_W-1:0] chText  [NUM_CHAN];
  logic [IV_W-1:0]   chIv    [NUM_CHAN];
  logic              chPass  [NUM_CHAN];
  logic              chStart [NUM_CHAN];
  logic [IV_W-1:0]   holdIv  [NUM_CHAN];
  logic              holdPass[NUM_CHAN];
  logic              flagV   [NUM_CHAN];
  logic              flagF   [NUM_CHAN];
  logic              flagT   [NUM_CHAN];

  assign chText[CHAN_TX]  = txText;
  assign chText[CHAN_RX]  = rxText;
  assign chIv[CHAN_TX]    = txIv;
  assign chIv[CHAN_RX]    = rxIv;
  assign chPass[CHAN_TX]  = txPass;
  assign chPass[CHAN_RX]  = rxPass;
  assign chStart[CHAN_TX] = strb.txStartOk;
  assign chStart[CHAN_RX] = strb.rxStartOk;

  genvar ch;
  generate
    for (ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
      localparam logic [CH_W-1:0] CH_ID = CH_W'(ch);

      // parameters held from the channel's last accepted start
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          holdIv[ch]   <= '0;
          holdPass[ch] <= 1'b0;
        end else if (chStart[ch]) begin
          holdIv[ch]   <= chIv[ch];
          holdPass[ch] <= chPass[ch];
        end
      end

      // return flags steered by the returned channel tag
      always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
          flagV[ch] <= 1'b0;
          flagF[ch] <= 1'b0;
          flagT[ch] <= 1'b0;
        end else begin
          flagV[ch] <= retTextValid && (retChan == CH_ID[0]);
          flagF[ch] <= retTextFirst && (retChan == CH_ID[0]);
          flagT[ch] <= retTagValid  && (retChan == CH_ID[0]);
        end
      end
    end
  endgenerate

  logic              own;
  logic              ownStart;
  logic [IV_W-1:0]   selIv;
  logic              selPass;

  always_comb begin
    own      = strb.slot;
    ownStart = chStart[own];
    selIv    = ownStart ? chIv[own]   : holdIv[own];
    selPass  = ownStart ? chPass[own] : holdPass[own];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      dpText  <= '0;
      dpIv    <= '0;
      dpFirst <= 1'b0;
      dpPass  <= 1'b0;
      dpChan  <= 1'b0;
      outText <= '0;
      outTag  <= '0;
    end else begin
      dpText  <= chText[own];
      dpIv    <= selIv;
      dpFirst <= ownStart;
      dpPass  <= selPass;
      dpChan  <= own;
      outText <= retText;
      outTag  <= retTag;
    end
  end

  assign txOutValid = flagV[CHAN_TX];
  assign txOutFirst = flagF[CHAN_TX];
  assign txTagValid = flagT[CHAN_TX];
  assign rxOutValid = flagV[CHAN_RX];
  assign rxOutFirst = flagF[CHAN_RX];
  assign rxTagValid = flagT[CHAN_RX];

  // R6
  no_rx_leak_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(retChan)) |-> !(txOutValid || txOutFirst || txTagValid));

  // R6
  split_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((txOutValid || txOutFirst || txTagValid) && (rxOutValid || rxOutFirst || rxTagValid)));

  // R3
  first_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && dpFirst) |-> (dpChan == $past(strb.slot)));

endmodule

// File: rtl/duplex_slot_mux.sv
module duplex_slot_mux
  import slot_mux_pkg::*;
#(
  parameter int unsigned TEXT_W = 128,
  parameter int unsigned IV_W   = 96,
  parameter int unsigned TAG_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txFirst,
  input  logic              txPass,
  input  logic [IV_W-1:0]   txIv,
  input  logic [TEXT_W-1:0] txText,
  input  logic              rxFirst,
  input  logic              rxPass,
  input  logic [IV_W-1:0]   rxIv,
  input  logic [TEXT_W-1:0] rxText,
  output logic              txSlot,
  output logic [TEXT_W-1:0] dpText,
  output logic [IV_W-1:0]   dpIv,
  output logic              dpFirst,
  output logic              dpPass,
  output logic              dpChan,
  input  logic              retTextValid,
  input  logic              retTextFirst,
  input  logic              retTagValid,
  input  logic              retChan,
  input  logic [TEXT_W-1:0] retText,
  input  logic [TAG_W-1:0]  retTag,
  output logic              txOutValid,
  output logic              txOutFirst,
  output logic              txTagValid,
  output logic              rxOutValid,
  output logic              rxOutFirst,
  output logic              rxTagValid,
  output logic [TEXT_W-1:0] outText,
  output logic [TAG_W-1:0]  outTag,
  output logic              protoErr
);

  slotStrb_t strb;

  slot_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .txFirst (txFirst),
    .rxFirst (rxFirst),
    .strb    (strb),
    .protoErr(protoErr)
  );

  slot_datapath #(
    .TEXT_W(TEXT_W),
    .IV_W  (IV_W),
    .TAG_W (TAG_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .txPass      (txPass),
    .txIv        (txIv),
    .txText      (txText),
    .rxPass      (rxPass),
    .rxIv        (rxIv),
    .rxText      (rxText),
    .dpText      (dpText),
    .dpIv        (dpIv),
    .dpFirst     (dpFirst),
    .dpPass      (dpPass),
    .dpChan      (dpChan),
    .retTextValid(retTextValid),
    .retTextFirst(retTextFirst),
    .retTagValid (retTagValid),
    .retChan     (retChan),
    .retText     (retText),
    .retTag      (retTag),
    .txOutValid  (txOutValid),
    .txOutFirst  (txOutFirst),
    .txTagValid  (txTagValid),
    .rxOutValid  (rxOutValid),
    .rxOutFirst  (rxOutFirst),
    .rxTagValid  (rxTagValid),
    .outText     (outText),
    .outTag      (outTag)
  );

  assign txSlot = strb.slot;

endmodule

// File: tb/duplex_slot_mux_bench.sv
`timescale 1ns/1ps
module duplex_slot_mux_bench;

  localparam int TW = 128;
  localparam int IW = 96;
  localparam int NCYC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          txFirst = 0, txPass = 0, rxFirst = 0, rxPass = 0;
  logic [IW-1:0] txIv = '0, rxIv = '0;
  logic [TW-1:0] txText = '0, rxText = '0, retText = '0, retTag = '0;
  logic          retTextValid = 0, retTextFirst = 0, retTagValid = 0, retChan = 0;

  logic          txSlot, dpFirst, dpPass, dpChan, protoErr;
  logic [TW-1:0] dpText, outText, outTag;
  logic [IW-1:0] dpIv;
  logic          txOutValid, txOutFirst, txTagValid, rxOutValid, rxOutFirst, rxTagValid;

  duplex_slot_mux u_duplex_slot_mux (
    .clk(clk), .rst(rst),
    .txFirst(txFirst), .txPass(txPass), .txIv(txIv), .txText(txText),
    .rxFirst(rxFirst), .rxPass(rxPass), .rxIv(rxIv), .rxText(rxText),
    .txSlot(txSlot), .dpText(dpText), .dpIv(dpIv), .dpFirst(dpFirst),
    .dpPass(dpPass), .dpChan(dpChan),
    .retTextValid(retTextValid), .retTextFirst(retTextFirst),
    .retTagValid(retTagValid), .retChan(retChan),
    .retText(retText), .retTag(retTag),
    .txOutValid(txOutValid), .txOutFirst(txOutFirst), .txTagValid(txTagValid),
    .rxOutValid(rxOutValid), .rxOutFirst(rxOutFirst), .rxTagValid(rxTagValid),
    .outText(outText), .outTag(outTag), .protoErr(protoErr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected state, built from the requirements
  logic          eSlot, eDpFirst, eDpPass, eDpChan, eErr;
  logic [TW-1:0] eDpText, eOutText, eOutTag;
  logic [IW-1:0] eDpIv, eTxHoldIv, eRxHoldIv;
  logic          eTxHoldPass, eRxHoldPass;
  logic [2:0]    eTxFl, eRxFl;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state, R1 slot during reset
    chk("R1", TW'(txSlot), TW'(1'b1));
    chk("R8", dpText, '0);
    chk("R8", TW'(dpIv), '0);
    chk("R8", TW'({dpFirst, dpPass, dpChan, protoErr}), '0);
    chk("R8", TW'({txOutValid, txOutFirst, txTagValid, rxOutValid, rxOutFirst, rxTagValid}), '0);
    chk("R8", outText ^ outTag, '0);
    rst = 1'b0;
    eSlot = 1'b1; eDpFirst = 0; eDpPass = 0; eDpChan = 0; eErr = 0;
    eDpText = '0; eOutText = '0; eOutTag = '0; eDpIv = '0;
    eTxHoldIv = '0; eRxHoldIv = '0; eTxHoldPass = 0; eRxHoldPass = 0;
    eTxFl = '0; eRxFl = '0;

    for (int i = 0; i < NCYC; i++) begin
      logic own, txOk, rxOk;
      logic [31:0] h;
      // compare with state produced by the previous edge
      chk("R1", TW'(txSlot), TW'(eSlot));
      chk("R2", TW'(dpChan), TW'(eDpChan));
      chk("R2", dpText, eDpText);
      chk("R3", TW'(dpFirst), TW'(eDpFirst));
      chk("R5", TW'(dpIv), TW'(eDpIv));
      chk("R5", TW'(dpPass), TW'(eDpPass));
      chk("R4", TW'(protoErr), TW'(eErr));
      chk("R6", TW'({txOutValid, txOutFirst, txTagValid}), TW'(eTxFl));
      chk("R6", TW'({rxOutValid, rxOutFirst, rxTagValid}), TW'(eRxFl));
      chk("R7", outText, eOutText);
      chk("R7", outTag, eOutTag);

      // stimulus for this cycle; misaligned starts only in the second half
      h = 32'(i) * 32'h9e3779b9;
      txFirst = (i % 7 == 0) || (i % 11 == 3);
      rxFirst = (i % 5 == 1) || (i % 13 == 6);
      if (i < NCYC / 2) begin
        if (!eSlot) txFirst = 0;
        if (eSlot)  rxFirst = 0;
      end
      txPass = h[3];
      rxPass = h[9];
      txIv   = {h, ~h, h ^ 32'h5a5a5a5a};
      rxIv   = {~h, h + 32'd17, h};
      txText = {h, h + 32'd1, h + 32'd2, h + 32'd3};
      rxText = {~h, h ^ 32'hffff0000, h - 32'd5, h};
      retTextValid = i[0];
      retTextFirst = i[1];
      retTagValid  = i[2];
      retChan      = i[3] ^ i[5];
      retText      = {4{h ^ 32'h0f0f0f0f}};
      retTag       = {4{~h + 32'd3}};

      // expected state after the coming edge
      own  = eSlot;
      txOk = txFirst && own;
      rxOk = rxFirst && !own;
      eDpChan  = own;
      eDpText  = own ? txText : rxText;
      eDpFirst = txOk || rxOk;
      if (own) begin
        eDpIv   = txOk ? txIv : eTxHoldIv;
        eDpPass = txOk ? txPass : eTxHoldPass;
      end else begin
        eDpIv   = rxOk ? rxIv : eRxHoldIv;
        eDpPass = rxOk ? rxPass : eRxHoldPass;
      end
      if (txOk) begin eTxHoldIv = txIv; eTxHoldPass = txPass; end
      if (rxOk) begin eRxHoldIv = rxIv; eRxHoldPass = rxPass; end
      if ((txFirst && !own) || (rxFirst && own)) eErr = 1'b1;
      eTxFl = retChan  ? {retTextValid, retTextFirst, retTagValid} : 3'b000;
      eRxFl = !retChan ? {retTextValid, retTextFirst, retTagValid} : 3'b000;
      eOutText = retText;
      eOutTag  = retTag;
      eSlot = ~eSlot;

      @(negedge clk);
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule